// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Tags

This block takes an asynchronous serial line and turns it into characters, using a single-cycle oversampling strobe that arrives sixteen times per bit period. A programmable line-control byte selects the number of data bits, the parity check, and whether one or two stop bits are expected. Every character that completes a frame is stored in a receive queue. Each queue entry carries its own framing, parity, break and overrun tags, so software can tell which character went wrong.

A small strobe-driven register port replaces a real bus. It exposes the queue head, a sticky error summary, a status byte and the line-control byte. Reading the data register removes the head entry. Writing any value to the error summary clears it. When the queue is switched off by the line-control byte, the receive path holds only a single character.

Top module: `rxq_uart_rx`

## Requirements
- R1: Data bits are assembled least significant bit first. The word length comes from line-control bits 6:5, where 00, 01, 10 and 11 select 5, 6, 7 and 8 bits. Entry bits above the word length read as zero.
- R2: Line-control bit 1 enables a parity bit and bit 2 selects even parity (clear means odd). With bit 7 also set, the parity bit is expected to be 1 when bit 2 is clear and 0 when bit 2 is set. A mismatch sets entry bit 9.
- R3: Line-control bit 3 selects two stop bits, otherwise one. Any stop bit sampled low sets entry bit 8.
- R4: If the line is low for the whole frame, including parity and stop bits, exactly one entry of value 0x500 is stored: the break tag (bit 10), the framing tag (bit 8) and data 0. The receiver then waits for the line to return high before it looks for a new start bit.
- R5: Each bit is sampled at oversample count 8. A start bit that is high again at that point is discarded and nothing is stored.
- R6: With line-control bit 4 set, the queue holds 32 entries; with it clear, it holds 1. Status bit 4 reports the queue empty and status bit 6 reports it full.
- R7: If a character completes while the queue is full, that character is dropped and bit 11 is set on the newest stored entry.
- R8: The error summary (address 1) holds framing at bit 0, parity at bit 1, break at bit 2 and overrun at bit 3. These bits accumulate until any write to address 1 clears all four.
- R9: Status bit 3 (busy) is set from start-bit detection until the frame is finished. After a break it stays set until the line returns high.
- R10: Reading address 0 returns the head entry and removes it. When the queue is empty, the read returns 0 and changes nothing. Address 2 is status (read only) and address 3 is the line-control byte (read/write), which resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| reg_addr | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe; reading address 0 removes the head entry |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register, combinational |

## Verification
Characters are sent under every word length and every parity mode. Each mode is run once with a correct parity bit and once with an inverted one, which separates the handling of data alignment, the parity sense and the stick-parity inversion. Frames with a low stop bit, an all-low frame and a short low pulse separate the framing tag from a break and from start-bit glitch rejection. Filling the 32-entry queue, and the single holding entry, past capacity shows that the overrun tag lands on the newest stored entry and that the extra character never appears.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int ENTRY_W = 12;
    localparam int REG_W   = 16;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_ERR  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_LCTL = 2'd3;

    // entry tag positions
    localparam int TAG_FRM = 8;
    localparam int TAG_PAR = 9;
    localparam int TAG_BRK = 10;
    localparam int TAG_OVR = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_WAITHI
    } rx_state_e;

    typedef struct packed {
        rx_state_e   st;
        logic [3:0]  cnt;
        logic [3:0]  nbit;
        logic [7:0]  shreg;
        logic        pbit;
        logic        zero;
        logic        ferr;
    } deframe_s;

endpackage

// File: rtl/rxq_deframer.sv
module rxq_deframer
    import rxq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               rxd,
    input  logic [7:0]         lctl,
    output logic               done,
    output logic [ENTRY_W-1:0] entry,
    output logic               busy
);

    localparam logic [3:0] MID_CNT = 4'd7;

    deframe_s q, d;

    logic       samp;
    logic       pen, even, stick, two_stop;
    logic [1:0] wlen;
    logic [3:0] last_bit;
    logic [7:0] data_al;
    logic       exp_par;
    logic       finish;

    always_comb begin
        wlen     = lctl[6:5];
        pen      = lctl[1];
        even     = lctl[2];
        two_stop = lctl[3];
        stick    = lctl[7];
        last_bit = {2'b00, wlen} + 4'd4;
        data_al  = q.shreg >> (2'd3 - wlen);
        if (stick)
            exp_par = ~even;
        else if (even)
            exp_par = ^data_al;
        else
            exp_par = ~(^data_al);
    end

    always_comb begin
        d      = q;
        done   = 1'b0;
        entry  = '0;
        finish = 1'b0;
        samp   = tick && (q.cnt == MID_CNT);
        if (tick)
            d.cnt = q.cnt + 4'd1;

        case (q.st)
            ST_IDLE: begin
                if (tick && !rxd) begin
                    d.st  = ST_START;
                    d.cnt = 4'd0;
                end
            end
            ST_START: begin
                if (samp) begin
                    if (rxd) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.st    = ST_DATA;
                        d.nbit  = 4'd0;
                        d.zero  = 1'b1;
                        d.shreg = '0;
                        d.ferr  = 1'b0;
                        d.pbit  = 1'b0;
                    end
                end
            end
            ST_DATA: begin
                if (samp) begin
                    d.shreg = {rxd, q.shreg[7:1]};
                    d.zero  = q.zero & ~rxd;
                    d.nbit  = q.nbit + 4'd1;
                    if (q.nbit == last_bit)
                        d.st = pen ? ST_PAR : ST_STOP1;
                end
            end
            ST_PAR: begin
                if (samp) begin
                    d.pbit = rxd;
                    d.zero = q.zero & ~rxd;
                    d.st   = ST_STOP1;
                end
            end
            ST_STOP1: begin
                if (samp) begin
                    d.zero = q.zero & ~rxd;
                    d.ferr = ~rxd;
                    if (two_stop)
                        d.st = ST_STOP2;
                    else
                        finish = 1'b1;
                end
            end
            ST_STOP2: begin
                if (samp) begin
                    d.zero = q.zero & ~rxd;
                    d.ferr = q.ferr | ~rxd;
                    finish = 1'b1;
                end
            end
            ST_WAITHI: begin
                if (tick && rxd)
                    d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (finish) begin
            done = 1'b1;
            if (d.zero) begin
                entry[TAG_BRK] = 1'b1;
                entry[TAG_FRM] = 1'b1;
                d.st           = ST_WAITHI;
            end else begin
                entry[7:0]     = data_al;
                entry[TAG_PAR] = pen && (q.pbit != exp_par);
                entry[TAG_FRM] = d.ferr;
                d.st           = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: 4'd0, nbit: 4'd0, shreg: 8'd0,
                   pbit: 1'b0, zero: 1'b0, ferr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 12,
    parameter int OVR_BIT = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_one,
    input  logic                     push,
    input  logic [W-1:0]             din,
    input  logic                     pop,
    output logic [W-1:0]             dout,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                     ovr
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rptr;
        logic [CW-1:0]           cnt;
    } fifo_s;

    fifo_s q, d;

    logic [CW-1:0] cap;
    logic [AW-1:0] newest;
    logic          do_pop, do_push;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        cap     = cap_one ? CW'(1) : CAP_FULL;
        empty   = (q.cnt == '0);
        full    = (q.cnt >= cap);
        newest  = (q.wptr == '0) ? LAST_IDX : q.wptr - AW'(1);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        ovr     = push && full && !do_pop;
        dout    = empty ? '0 : q.mem[q.rptr];
        count   = q.cnt;

        d = q;
        if (ovr)
            d.mem[newest][OVR_BIT] = 1'b1;
        if (do_push) begin
            d.mem[q.wptr] = din;
            d.wptr        = bump(q.wptr);
        end
        if (do_pop)
            d.rptr = bump(q.rptr);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/rxq_uart_rx.sv
module rxq_uart_rx
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             rxd,
    input  logic [1:0]       reg_addr,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [7:0] lctl;
        logic [3:0] sticky;
    } regs_s;

    regs_s q, d;

    logic               char_done;
    logic [ENTRY_W-1:0] char_entry;
    logic               rx_busy;
    logic               fifo_pop;
    logic [ENTRY_W-1:0] fifo_head;
    logic               fifo_empty, fifo_full, fifo_ovr;
    logic [CW-1:0]      fifo_count;
    logic [3:0]         sticky_set;
    logic [3:0]         sticky_q;

    rxq_deframer u_deframer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (os_tick),
        .rxd   (rxd),
        .lctl  (q.lctl),
        .done  (char_done),
        .entry (char_entry),
        .busy  (rx_busy)
    );

    rxq_fifo #(
        .DEPTH   (DEPTH),
        .W       (ENTRY_W),
        .OVR_BIT (TAG_OVR)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_one (~q.lctl[4]),
        .push    (char_done),
        .din     (char_entry),
        .pop     (fifo_pop),
        .dout    (fifo_head),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .count   (fifo_count),
        .ovr     (fifo_ovr)
    );

    always_comb begin
        fifo_pop = reg_rd && (reg_addr == ADDR_DATA);

        sticky_set = {fifo_ovr,
                      char_done & char_entry[TAG_BRK],
                      char_done & char_entry[TAG_PAR],
                      char_done & char_entry[TAG_FRM]};

        d = q;
        if (reg_wr && reg_addr == ADDR_LCTL)
            d.lctl = reg_wdata[7:0];
        if (reg_wr && reg_addr == ADDR_ERR)
            d.sticky = '0;
        d.sticky = d.sticky | sticky_set;

        reg_rdata = '0;
        case (reg_addr)
            ADDR_DATA: reg_rdata[ENTRY_W-1:0] = fifo_head;
            ADDR_ERR:  reg_rdata[3:0]         = q.sticky;
            ADDR_STAT: begin
                reg_rdata[3] = rx_busy;
                reg_rdata[4] = fifo_empty;
                reg_rdata[6] = fifo_full;
            end
            default:   reg_rdata[7:0]         = q.lctl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign sticky_q = q.sticky;

endmodule

// File: rtl/rxq_uart_rx_chk.sv
module rxq_uart_rx_chk #(
    parameter int DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_rd,
    input logic                       reg_wr,
    input logic [1:0]                 reg_addr,
    input logic                       char_done,
    input logic                       empty,
    input logic                       full,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic [3:0]                 sticky_set,
    input logic [3:0]                 sticky
);

    // R6: occupancy never exceeds the configured storage
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ($clog2(DEPTH+1))'(DEPTH));

    // R6: empty and full never reported together
    a_r6_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R10: reading an empty queue leaves it empty
    a_r10_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && empty && !char_done) |=> empty);

    // R8: a write to the summary clears it when nothing new is flagged
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && sticky_set == 4'd0) |=> (sticky == 4'd0));

    // R7: a full queue keeps its occupancy until something is read
    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(reg_rd && reg_addr == 2'd0)) |=> (fill == $past(fill)));

endmodule

bind rxq_uart_rx rxq_uart_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .char_done  (char_done),
    .empty      (fifo_empty),
    .full       (fifo_full),
    .fill       (fifo_count),
    .sticky_set (sticky_set),
    .sticky     (sticky_q)
);

// File: tb/rxq_uart_rx_test.sv
module rxq_uart_rx_test;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_tick = 1'b0;
    logic        rxd = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [11:0] mq[$];
    logic [3:0]  msticky = 4'd0;
    logic [7:0]  mlcr = 8'd0;

    rxq_uart_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #2.5 clk = ~clk;

    int tdiv = 0;
    always @(posedge clk) begin
        tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == TICK_DIV - 1);
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_lcr(input logic [7:0] v);
        wr(2'd3, {8'd0, v});
        mlcr = v;
    endtask

    task automatic model_push(input logic [11:0] e);
        int cap;
        cap = mlcr[4] ? 32 : 1;
        msticky = msticky | e[11:8];
        if (mq.size() >= cap) begin
            mq[mq.size()-1][11] = 1'b1;
            msticky[3] = 1'b1;
        end else begin
            mq.push_back(e);
        end
    endtask

    task automatic hold_bit(input logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] dat, input bit bad_par, input bit bad_stop);
        int nb;
        logic [7:0] dm;
        logic pb;
        nb = 5 + int'(mlcr[6:5]);
        dm = dat & ((8'd1 << nb) - 8'd1);
        if (mlcr[7])      pb = ~mlcr[2];
        else if (mlcr[2]) pb = ^dm;
        else              pb = ~(^dm);
        if (bad_par) pb = ~pb;
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) hold_bit(dm[i]);
        if (mlcr[1]) hold_bit(pb);
        if (mlcr[3]) begin
            hold_bit(1'b1);
            hold_bit(~bad_stop);
        end else begin
            hold_bit(~bad_stop);
        end
        rxd = 1'b1;
        model_push({1'b0, 1'b0, mlcr[1] & bad_par, bad_stop, dm});
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_break();
        int nbits;
        nbits = 1 + 5 + int'(mlcr[6:5]) + int'(mlcr[1]) + 1 + int'(mlcr[3]);
        @(negedge clk);
        rxd = 1'b0;
        repeat ((nbits + 3) * BIT_CLKS) @(negedge clk);
        rxd = 1'b1;
        model_push(12'h500);
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic drain(input string req);
        logic [15:0] v;
        while (mq.size() > 0) begin
            rd(2'd0, v);
            check(req, v, {4'd0, mq.pop_front()});
        end
        rd(2'd2, v);
        check(req, v, 16'h0010);
    endtask

    task automatic check_err(input string req);
        logic [15:0] v;
        rd(2'd1, v);
        check(req, v, {12'd0, msticky});
    endtask

    task automatic clear_err();
        wr(2'd1, 16'h1234);
        msticky = 4'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // reset state (R10, R6, R8)
        rd(2'd2, v);  check("R6 reset status", v, 16'h0010);
        rd(2'd1, v);  check("R8 reset summary", v, 16'h0000);
        rd(2'd3, v);  check("R10 reset line control", v, 16'h0000);
        rd(2'd0, v);  check("R10 empty read", v, 16'h0000);

        // R1 word lengths, queue on, no parity
        set_lcr(8'h70);
        send_char(8'hA5, 0, 0);
        send_char(8'h3C, 0, 0);
        drain("R1 8-bit");
        set_lcr(8'h10); send_char(8'hFF, 0, 0); send_char(8'h0A, 0, 0); drain("R1 5-bit");
        set_lcr(8'h30); send_char(8'hEB, 0, 0); drain("R1 6-bit");
        set_lcr(8'h50); send_char(8'hC1, 0, 0); drain("R1 7-bit");

        // R2 parity modes: even, odd, stick one, stick zero
        set_lcr(8'h76); send_char(8'h37, 0, 0); send_char(8'h37, 1, 0); drain("R2 even");
        set_lcr(8'h72); send_char(8'h37, 0, 0); send_char(8'h36, 1, 0); drain("R2 odd");
        set_lcr(8'hF2); send_char(8'h5A, 0, 0); send_char(8'h5A, 1, 0); drain("R2 stick one");
        set_lcr(8'hF6); send_char(8'h81, 0, 0); send_char(8'h81, 1, 0); drain("R2 stick zero");
        check_err("R8 parity summary");
        clear_err();
        check_err("R8 cleared");

        // R3 stop bits
        set_lcr(8'h78); send_char(8'h66, 0, 0); send_char(8'h66, 0, 1); drain("R3 two stop");
        set_lcr(8'h70); send_char(8'h99, 0, 1); drain("R3 one stop");
        check_err("R8 framing summary");
        clear_err();

        // R4 break
        set_lcr(8'h72);
        send_break();
        rd(2'd2, v); check("R4 break single entry status", v, 16'h0000);
        drain("R4 break entry");
        check_err("R8 break summary");
        clear_err();

        // R5 glitch start
        @(negedge clk);
        rxd = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        rd(2'd2, v); check("R5 glitch rejected", v, 16'h0010);

        // R9 busy mid-frame
        set_lcr(8'h70);
        fork
            send_char(8'h42, 0, 0);
        join_none
        repeat (3 * BIT_CLKS) @(negedge clk);
        rd(2'd2, v); check("R9 busy during frame", v, 16'h0018);
        wait fork;
        rd(2'd2, v); check("R9 idle after frame", v, 16'h0000);
        drain("R9 char");

        // R6/R7 deep queue overflow
        for (int i = 0; i < 32; i++) send_char(8'(i * 7 + 1), 0, 0);
        rd(2'd2, v); check("R6 full status", v, 16'h0040);
        send_char(8'hEE, 0, 0);
        check_err("R7 overrun summary");
        drain("R7 deep overrun");
        clear_err();

        // R6/R7 single holding entry
        set_lcr(8'h60);
        send_char(8'h11, 0, 0);
        rd(2'd2, v); check("R6 single full", v, 16'h0040);
        send_char(8'h22, 0, 0);
        drain("R7 holding overrun");
        check_err("R7 holding summary");
        clear_err();

        // R10 empty read changes nothing
        rd(2'd0, v); check("R10 empty read", v, 16'h0000);
        rd(2'd2, v); check("R10 still empty", v, 16'h0010);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule